// File: doc/BRIEF.md
# GPIO Interrupt Cause and Mask Unit

This block is the interrupt front end for a bank of general-purpose input lines. Each pin passes through its own polarity inverter, and the result is the line's adjusted input. The block then derives two kinds of interrupt cause from that value. A level cause follows the adjusted input directly. An edge cause is latched when the adjusted input goes from low to high and stays latched until software clears it. Each path has its own mask. The masked causes are ORed together per line.

The per-line causes are reduced in groups of eight into summary outputs for a main interrupt controller. Software uses a small word-addressed register port to do four things: read the adjusted inputs, set polarity, set both masks, and inspect or clear the latched edge causes. Because the inversion comes before the edge detector, one rising detector handles both directions. To catch the opposite edge next, software flips a line's polarity bit, and that flip on its own never latches a cause. Pins are assumed to arrive already synchronised.

Top module: `gpio_irq_front`

## Requirements
- R1: Reading word address 0 returns the adjusted input, which is `pin_i ^ polarity`. The polarity register is at word address 1.
- R2: With level mask bit n set (level mask at word address 2), line n raises its group output while its adjusted input is 1 and drops it as soon as the input returns to 0. No level state is latched.
- R3: An edge-cause bit (edge cause at word address 4) is set on the clock edge where the adjusted input of its line goes from 0 to 1. It stays set after the pin returns.
- R4: Polarity 0 makes a line's edge cause respond to a rising pin. Polarity 1 makes it respond to a falling pin and not to a rising one.
- R5: Changing a polarity bit while the pin stays steady never sets that line's edge-cause bit, whichever way the bit is changed.
- R6: A write to the edge-cause word clears every bit written as 0 and keeps every bit written as 1. If a new edge on a bit arrives in the same cycle as a clear of that bit, the bit ends up set.
- R7: The edge mask at word address 3 gates the edge-cause contribution to the outputs. A cause is still latched while its line is masked.
- R8: `irq_o[g]` is the OR of the per-line causes of lines 8g to 8g+7.
- R9: After reset, the polarity, level mask, edge mask and edge cause registers all read 0 and every `irq_o` bit is 0.
- R10: The adjusted-input word is read-only, so a write to address 0 does not change what it reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Synchronised pin levels |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 4 | Summary interrupt per group of eight lines |

## Verification
The assertions assume that `pin_i` is already synchronous to `clk_i` and changes only between clock edges. On that basis, any newly latched edge cause can be traced to a pin change in the preceding cycle. They also assume that the only thing that ever clears a cause bit is a write to the cause address. The bench meets these assumptions by changing pins and register strobes only on falling clock edges and by leaving pins steady across every polarity write. This makes the polarity-flip checks true isolation tests.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIN   = 3'd0,
    REG_POL   = 3'd1,
    REG_LMASK = 3'd2,
    REG_EMASK = 3'd3,
    REG_CAUSE = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [NUM_LINES-1:0] pol_i,
  input  logic                 clr_we_i,
  input  logic [NUM_LINES-1:0] keep_i,
  output logic [NUM_LINES-1:0] cause_o
);
  logic [NUM_LINES-1:0] pin_q, cause_q, rise;
  logic                 primed_q;

  // edge = pin toggled and lands at adjusted 1; a pure polarity flip never qualifies
  assign rise = {NUM_LINES{primed_q}} & (pin_i ^ pin_q) & (pin_i ^ pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q    <= '0;
      primed_q <= 1'b0;
      cause_q  <= '0;
    end else begin
      pin_q    <= pin_i;
      primed_q <= 1'b1;
      if (clr_we_i) cause_q <= (cause_q & keep_i) | rise;
      else          cause_q <= cause_q | rise;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic [NUM_LINES-1:0] din_i,
  input  logic [NUM_LINES-1:0] cause_i,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] lmask_o,
  output logic [NUM_LINES-1:0] emask_o,
  output logic                 clr_we_o,
  output logic [NUM_LINES-1:0] rdata_o
);
  logic [NUM_LINES-1:0] pol_q, lmask_q, emask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q   <= '0;
      lmask_q <= '0;
      emask_q <= '0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        REG_POL:   pol_q   <= wdata_i;
        REG_LMASK: lmask_q <= wdata_i;
        REG_EMASK: emask_q <= wdata_i;
        default:   ;
      endcase
    end
  end

  assign clr_we_o = we_i && (reg_addr_e'(addr_i) == REG_CAUSE);

  always_comb begin
    case (reg_addr_e'(addr_i))
      REG_DIN:   rdata_o = din_i;
      REG_POL:   rdata_o = pol_q;
      REG_LMASK: rdata_o = lmask_q;
      REG_EMASK: rdata_o = emask_q;
      REG_CAUSE: rdata_o = cause_i;
      default:   rdata_o = '0;
    endcase
  end

  assign pol_o   = pol_q;
  assign lmask_o = lmask_q;
  assign emask_o = emask_q;
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned GROUP_SIZE = 8,
  localparam int unsigned NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input  logic [NUM_LINES-1:0]  line_cause_i,
  output logic [NUM_GROUPS-1:0] irq_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign irq_o[g] = |line_cause_i[g*GROUP_SIZE +: GROUP_SIZE];
  end
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned GROUP_SIZE = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_LINES-1:0]              pin_i,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [NUM_LINES-1:0]              wdata_i,
  output logic [NUM_LINES-1:0]              rdata_o,
  output logic [NUM_LINES/GROUP_SIZE-1:0]   irq_o
);
  logic [NUM_LINES-1:0] pol, lmask, emask, din, edge_cause, line_cause;
  logic                 clr_we;

  assign din        = pin_i ^ pol;
  assign line_cause = (din & lmask) | (edge_cause & emask);

  gpio_irq_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .din_i(din), .cause_i(edge_cause),
    .pol_o(pol), .lmask_o(lmask), .emask_o(emask),
    .clr_we_o(clr_we), .rdata_o
  );

  gpio_irq_edge #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk_i, .rst_ni, .pin_i, .pol_i(pol),
    .clr_we_i(clr_we), .keep_i(wdata_i), .cause_o(edge_cause)
  );

  gpio_irq_group #(.NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_group (
    .line_cause_i(line_cause), .irq_o
  );
endmodule

// File: rtl/gpio_irq_front_chk.sv
module gpio_irq_front_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned NUM_GROUPS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_LINES-1:0]  pin_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [NUM_LINES-1:0]  cause,
  input logic [NUM_LINES-1:0]  lmask,
  input logic [NUM_LINES-1:0]  emask,
  input logic [NUM_GROUPS-1:0] irq_o
);
  // R3 / R5: a newly latched cause needs a pin toggle in the previous cycle
  p_new_cause_from_pin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause & ~$past(cause)) & ~($past(pin_i) ^ $past(pin_i, 2))) == '0);

  // R6: cause bits fall only after a write to the cause address
  p_cause_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i && addr_i == REG_CAUSE) |-> (($past(cause) & ~cause) == '0));

  // R2: any output needs some enabled source
  p_irq_needs_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ((lmask | emask) != '0));

  // R7: with no level mask, an output requires an unmasked latched edge
  p_irq_edge_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0 && lmask == '0) |-> ((cause & emask) != '0));
endmodule

bind gpio_irq_front gpio_irq_front_chk #(
  .NUM_LINES(NUM_LINES), .NUM_GROUPS(NUM_LINES/GROUP_SIZE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .we_i(we_i), .addr_i(addr_i),
  .cause(edge_cause), .lmask(lmask), .emask(emask), .irq_o(irq_o)
);

// File: tb/gpio_irq_front_bench.sv
module gpio_irq_front_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pin_i = '0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_irq_front u_gpio_irq_front (
    .clk_i, .rst_ni, .pin_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  localparam logic [2:0] A_DIN = 3'd0, A_POL = 3'd1, A_LM = 3'd2, A_EM = 3'd3, A_CA = 3'd4;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic clean();
    pin_i = '0;
    wr(A_POL, '0); wr(A_LM, '0); wr(A_EM, '0); wr(A_CA, '0);
  endtask

  task automatic t_reset();
    step();
    rd_chk("R9", A_POL, '0);
    rd_chk("R9", A_LM, '0);
    rd_chk("R9", A_EM, '0);
    rd_chk("R9", A_CA, '0);
    chk("R9", {28'd0, irq_o}, '0);
  endtask

  task automatic t_polarity();
    clean();
    pin_i = 32'hA5A5_3C3C;
    wr(A_POL, 32'hFFFF_0000);
    rd_chk("R1", A_DIN, 32'hA5A5_3C3C ^ 32'hFFFF_0000);
    wr(A_DIN, 32'h1234_5678);
    rd_chk("R10", A_DIN, 32'hA5A5_3C3C ^ 32'hFFFF_0000);
  endtask

  task automatic t_level();
    clean();
    wr(A_LM, 32'h8000_0100);
    pin_i = 32'h0000_0100; #1;
    chk("R2", {28'd0, irq_o}, 32'h2);
    pin_i = 32'h8000_0000; #1;
    chk("R8", {28'd0, irq_o}, 32'h8);
    pin_i = '0; #1;
    chk("R2", {28'd0, irq_o}, 32'h0);
  endtask

  task automatic t_edge();
    clean();
    pin_i[0] = 1'b1; step();
    rd_chk("R3", A_CA, 32'h1);
    chk("R7", {28'd0, irq_o}, 32'h0);
    wr(A_EM, 32'h1); #1;
    chk("R7", {28'd0, irq_o}, 32'h1);
    pin_i[0] = 1'b0; step();
    rd_chk("R3", A_CA, 32'h1);
    wr(A_POL, 32'h2);
    rd_chk("R5", A_CA, 32'h1);
    pin_i[1] = 1'b1; step();
    rd_chk("R4", A_CA, 32'h1);
    pin_i[1] = 1'b0; step();
    rd_chk("R4", A_CA, 32'h3);
  endtask

  task automatic t_clear();
    wr(A_CA, 32'hFFFF_FFFE);
    rd_chk("R6", A_CA, 32'h2);
    @(negedge clk_i);
    pin_i[2] = 1'b1;
    we_i = 1'b1; addr_i = A_CA; wdata_i = 32'hFFFF_FFF9;
    @(negedge clk_i);
    we_i = 1'b0;
    rd_chk("R6", A_CA, 32'h4);
  endtask

  task automatic t_flip();
    clean();
    pin_i[3] = 1'b1; step();
    rd_chk("R3", A_CA, 32'h8);
    wr(A_CA, '0);
    wr(A_POL, 32'h8);
    rd_chk("R5", A_CA, 32'h0);
    wr(A_POL, 32'h0);
    rd_chk("R5", A_CA, 32'h0);
  endtask

  task automatic t_groups();
    clean();
    wr(A_EM, 32'h0010_0000);
    pin_i[20] = 1'b1; step(); #1;
    chk("R8", {28'd0, irq_o}, 32'h4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_polarity();
    t_level();
    t_edge();
    t_clear();
    t_flip();
    t_groups();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule